// File: doc/BRIEF.md
# Link Power Monitor and Wake Signaller

This block sits in the PHY of a serial bus. It runs on the system clock that the PHY supplies to the link controller. It watches the link controller's power status input, which is asynchronous. When that input has been low for a short while, the block resets the PHY/link interface. When it stays low much longer, the block disables the interface. The interface comes back as soon as the input is seen high again. The repeater side of the PHY is not affected.

The block also drives a wake line so that a sleeping link controller can power itself up. Two kinds of event raise the wake: a link-on packet addressed to this node, or a register interrupt condition. While the wake is raised, the line carries a square wave at one eighth of the system clock. Every wake ends when the link reports power again. A bus reset ends a wake only when a link-on packet alone caused it.

The same pin has a second use during hardware reset. It is read as an input, and the level read sets the default bus-manager contender bit. After reset the block drives the pin.

Top module: `link_power_wake`

## Requirements
- R1: During reset, `if_reset`, `if_disable`, `wake_out` and `wake_oe` are all 0. `wake_oe` reads 1 from the first clock edge after reset is released and stays 1.
- R2: `contender` takes the level on `wake_pin_in` that is sampled on the clock edges while reset is active. Changes on `wake_pin_in` after reset do not change it.
- R3: `lps_in` passes through a two-flop synchroniser before it is timed. The idle count restarts from 0 one cycle after the synchronised status is high.
- R4: `if_reset` is 1 while the idle count is at least RESET_CYC (default 59) and below DISABLE_CYC. An inactive gap that ends before RESET_CYC cycles does not raise it.
- R5: `if_disable` is 1 once the idle count reaches DISABLE_CYC (default 1229). At that point `if_reset` returns to 0. Both outputs fall once the synchronised status is high.
- R6: A `linkon_pkt` strobe raises the wake while the link is down. "Link down" means an idle count of at least RESET_CYC.
- R7: While the link is down, `irq_port_event`=1 raises the wake. `irq_timeout`, `irq_pwr_fail` or `irq_loop` raise it only when `irq_resume_en`=1.
- R8: Once raised, the wake stays up even after the interrupt flags clear. It stays up until the synchronised status is high.
- R9: A `bus_reset` strobe clears the wake only if every raising event so far has been a link-on packet. Once an interrupt has taken part in the wake, a bus reset does not clear it.
- R10: An interrupt condition that is present while the link is up raises the wake as soon as the link goes down.
- R11: `wake_out` carries a square wave of period 8 cycles. The wave is high for the cycles where (cycles since reset release) mod 8 is 4 to 7. `wake_out` is 0 whenever the wake is down.
- R12: A `linkon_pkt` strobe while the link is not down has no effect on `wake_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| lps_in | input | 1 | Link power status, asynchronous, 1 = link powered |
| linkon_pkt | input | 1 | One-cycle strobe: link-on packet for this node received |
| bus_reset | input | 1 | One-cycle strobe: bus reset occurred |
| irq_port_event | input | 1 | Port event interrupt flag |
| irq_timeout | input | 1 | Timeout interrupt flag |
| irq_pwr_fail | input | 1 | Cable power fail interrupt flag |
| irq_loop | input | 1 | Loop detect interrupt flag |
| irq_resume_en | input | 1 | Resume interrupt enable |
| wake_pin_in | input | 1 | Level seen on the wake pin |
| wake_out | output | 1 | Wake pin output value |
| wake_oe | output | 1 | Wake pin output enable |
| contender | output | 1 | Contender bit latched during reset |
| if_reset | output | 1 | PHY/link interface reset request |
| if_disable | output | 1 | PHY/link interface disable |

## Verification
The assertions assume two things about the inputs. The link-on and bus-reset strobes are each one cycle wide. The interrupt flags are levels that change only between clock edges. The bench drives every input a fixed delay after the rising edge, so the synchroniser never sees a change at the edge. It keeps the strobes to single cycles. It holds each status level long enough to pass the short threshold, or deliberately stops short of it. The assertion that the disable is preceded by the reset request holds only because RESET_CYC is below DISABLE_CYC, as it is in the default parameters.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    WAKE_IDLE = 2'd0,
    WAKE_PKT  = 2'd1,
    WAKE_IRQ  = 2'd2
  } wake_cause_e;

  // interrupt condition that may raise the wake
  function automatic logic wake_irq(input logic port_ev, input logic tmo,
                                    input logic pfail, input logic lp,
                                    input logic res_en);
    return port_ev | (res_en & (tmo | pfail | lp));
  endfunction

  // saturating increment of the idle counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES:0] chain;
  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/lpw_idle_timer.sv
module lpw_idle_timer #(
  parameter int unsigned RESET_CYC   = 59,
  parameter int unsigned DISABLE_CYC = 1229
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_sync,
  output logic link_down,
  output logic if_reset,
  output logic if_disable
);
  import lpw_pkg::*;
  localparam int CW = $clog2(DISABLE_CYC + 1);
  localparam logic [CW-1:0] RST_L = CW'(RESET_CYC);
  localparam logic [CW-1:0] DIS_L = CW'(DISABLE_CYC);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        idle_cnt <= '0;
    else if (lps_sync) idle_cnt <= '0;
    else               idle_cnt <= CW'(sat_inc(int'(idle_cnt), DISABLE_CYC));
  end

  assign link_down  = (idle_cnt >= RST_L);
  assign if_disable = (idle_cnt >= DIS_L);
  assign if_reset   = link_down && !if_disable;
endmodule

// File: rtl/lpw_clkdiv.sv
module lpw_clkdiv #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  logic [DIV_LOG2-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  assign wave = div_cnt[DIV_LOG2-1];
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_sync,
  input  logic link_down,
  input  logic irq_now,
  input  logic linkon_pkt,
  input  logic bus_reset,
  output logic wake_active
);
  import lpw_pkg::*;
  wake_cause_e cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (lps_sync)
      cause_d = WAKE_IDLE;
    else if (link_down && irq_now)
      cause_d = WAKE_IRQ;
    else if (link_down && linkon_pkt)
      cause_d = (cause_q == WAKE_IRQ) ? WAKE_IRQ : WAKE_PKT;
    else if (bus_reset && cause_q == WAKE_PKT)
      cause_d = WAKE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= WAKE_IDLE;
    else        cause_q <= cause_d;
  end

  assign wake_active = (cause_q != WAKE_IDLE);
endmodule

// File: rtl/link_power_wake.sv
module link_power_wake #(
  parameter int unsigned RESET_CYC   = 59,
  parameter int unsigned DISABLE_CYC = 1229,
  parameter int          SYNC_STAGES = 2,
  parameter int          DIV_LOG2    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_in,
  input  logic linkon_pkt,
  input  logic bus_reset,
  input  logic irq_port_event,
  input  logic irq_timeout,
  input  logic irq_pwr_fail,
  input  logic irq_loop,
  input  logic irq_resume_en,
  input  logic wake_pin_in,
  output logic wake_out,
  output logic wake_oe,
  output logic contender,
  output logic if_reset,
  output logic if_disable
);
  import lpw_pkg::*;

  // named internal events, visible to the checker
  logic lps_sync;
  logic link_down;
  logic irq_now;
  logic wake_active;
  logic wave;
  logic oe_q;
  logic contender_q;

  lpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lps_in), .q(lps_sync)
  );

  lpw_idle_timer #(.RESET_CYC(RESET_CYC), .DISABLE_CYC(DISABLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .lps_sync(lps_sync),
    .link_down(link_down), .if_reset(if_reset), .if_disable(if_disable)
  );

  assign irq_now = wake_irq(irq_port_event, irq_timeout, irq_pwr_fail,
                            irq_loop, irq_resume_en);

  lpw_wake_ctrl u_wake (
    .clk(clk), .rst_n(rst_n), .lps_sync(lps_sync), .link_down(link_down),
    .irq_now(irq_now), .linkon_pkt(linkon_pkt), .bus_reset(bus_reset),
    .wake_active(wake_active)
  );

  lpw_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .wave(wave)
  );

  // pin is an input during reset, an output afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q        <= 1'b0;
      contender_q <= wake_pin_in;
    end else begin
      oe_q        <= 1'b1;
    end
  end

  assign wake_oe   = oe_q;
  assign contender = contender_q;
  assign wake_out  = wake_active & wave & oe_q;
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker (
  input logic clk,
  input logic rst_n,
  input logic lps_sync,
  input logic link_down,
  input logic irq_now,
  input logic linkon_pkt,
  input logic bus_reset,
  input logic wake_active,
  input logic wake_out,
  input logic wake_oe,
  input logic if_reset,
  input logic if_disable
);
  // R1
  oe_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wake_oe);

  // R5
  reset_disable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_reset && if_disable));

  // R5
  disable_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_disable) |-> $past(if_reset));

  // R11
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_active |-> !wake_out);

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_active && !lps_sync && !bus_reset |=> wake_active);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_now && link_down && !lps_sync |=> wake_active);

  // R6
  pkt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkon_pkt && link_down && !lps_sync |=> wake_active);

  // R8
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lps_sync |=> !wake_active);
endmodule

bind link_power_wake lpw_checker u_lpw_checker (
  .clk(clk), .rst_n(rst_n), .lps_sync(lps_sync), .link_down(link_down),
  .irq_now(irq_now), .linkon_pkt(linkon_pkt), .bus_reset(bus_reset),
  .wake_active(wake_active), .wake_out(wake_out), .wake_oe(wake_oe),
  .if_reset(if_reset), .if_disable(if_disable)
);

// File: tb/test_link_power_wake.sv
`timescale 1ns/1ps
module test_link_power_wake;
  localparam int RST_T = 59;
  localparam int DIS_T = 1229;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_in = 1'b1, linkon_pkt = 1'b0, bus_reset = 1'b0;
  logic irq_port_event = 1'b0, irq_timeout = 1'b0, irq_pwr_fail = 1'b0;
  logic irq_loop = 1'b0, irq_resume_en = 1'b0, wake_pin_in = 1'b1;
  logic wake_out, wake_oe, contender, if_reset, if_disable;

  always #4 clk = ~clk;

  link_power_wake i_link_power_wake (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .linkon_pkt(linkon_pkt),
    .bus_reset(bus_reset), .irq_port_event(irq_port_event),
    .irq_timeout(irq_timeout), .irq_pwr_fail(irq_pwr_fail),
    .irq_loop(irq_loop), .irq_resume_en(irq_resume_en),
    .wake_pin_in(wake_pin_in), .wake_out(wake_out), .wake_oe(wake_oe),
    .contender(contender), .if_reset(if_reset), .if_disable(if_disable)
  );

  int checks = 0, errors = 0, wd = 0;
  string cur_req = "R1";

  // behavioural reference: history queue for the status, integers for the rest
  bit hist[$];
  int idle = 0, since_rst = 0, m_valid = 0;
  bit m_wake = 0, m_pkt_only = 0, m_oe = 0, m_con = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      idle = 0; since_rst = 0; m_wake = 0; m_pkt_only = 0; m_oe = 0;
      m_con = wake_pin_in; m_valid = 1;
    end else begin
      bit seen, down, irq;
      seen = hist[0];
      down = (idle >= RST_T);
      irq  = irq_port_event || (irq_resume_en && (irq_timeout || irq_pwr_fail || irq_loop));
      if (seen) begin m_wake = 0; m_pkt_only = 0; end
      else if (down && irq) begin m_wake = 1; m_pkt_only = 0; end
      else if (down && linkon_pkt) begin m_pkt_only = m_pkt_only || !m_wake; m_wake = 1; end
      else if (bus_reset && m_pkt_only) begin m_wake = 0; m_pkt_only = 0; end
      idle = seen ? 0 : ((idle < DIS_T) ? idle + 1 : idle);
      void'(hist.pop_front());
      hist.push_back(lps_in);
      since_rst++;
      m_oe = 1;
    end
  end

  task automatic chk(string nm, string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid != 0) begin
      chk("wake_oe",    "R1", wake_oe, m_oe);
      chk("contender",  "R2", contender, m_con);
      chk("if_reset",   cur_req, if_reset,   (idle >= RST_T) && (idle < DIS_T));
      chk("if_disable", cur_req, if_disable, idle >= DIS_T);
      chk("wake_out",   cur_req, wake_out,   m_wake && ((since_rst % 8) >= 4));
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=200000 cycles", wd);
      summary();
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic strobe_pkt();
    linkon_pkt = 1'b1; cyc(1); linkon_pkt = 1'b0;
  endtask

  task automatic strobe_br();
    bus_reset = 1'b1; cyc(1); bus_reset = 1'b0;
  endtask

  initial begin
    cur_req = "R1"; cyc(5);
    rst_n = 1'b1; wake_pin_in = 1'b0;           // R2: later pin level ignored
    cyc(10);
    cur_req = "R12"; strobe_pkt(); cyc(20);      // packet while link up
    cur_req = "R3"; lps_in = 1'b0; cyc(30); lps_in = 1'b1; cyc(10);  // short gap, R4 boundary
    cur_req = "R4"; lps_in = 1'b0; cyc(200); lps_in = 1'b1; cyc(10);
    cur_req = "R5"; lps_in = 1'b0; cyc(1400);
    cur_req = "R6"; strobe_pkt(); cyc(5);
    cur_req = "R11"; cyc(24);
    cur_req = "R9"; strobe_br(); cyc(10);        // packet-only wake clears
    strobe_pkt(); cyc(5);
    irq_port_event = 1'b1; cyc(1); irq_port_event = 1'b0; cyc(3);
    strobe_br(); cyc(12);                        // now interrupt-backed: held
    cur_req = "R8"; cyc(20); lps_in = 1'b1; cyc(10);
    cur_req = "R7"; irq_timeout = 1'b1; lps_in = 1'b0; cyc(100);
    irq_resume_en = 1'b1; cyc(20);
    irq_timeout = 1'b0; irq_resume_en = 1'b0; cyc(10); lps_in = 1'b1; cyc(10);
    irq_loop = 1'b1; irq_pwr_fail = 1'b1; lps_in = 1'b0; cyc(90);
    irq_loop = 1'b0; irq_pwr_fail = 1'b0; lps_in = 1'b1; cyc(10);
    cur_req = "R10"; irq_port_event = 1'b1; cyc(10); lps_in = 1'b0; cyc(80);
    irq_port_event = 1'b0; cyc(20); lps_in = 1'b1; cyc(10);
    cur_req = "R12"; lps_in = 1'b0; cyc(20); strobe_pkt(); cyc(60); lps_in = 1'b1; cyc(10);
    cur_req = "R1"; rst_n = 1'b0; wake_pin_in = 1'b0; cyc(4);
    rst_n = 1'b1; wake_pin_in = 1'b1; cyc(20);   // R2 with the opposite level
    summary();
    $finish;
  end
endmodule